// File: doc/BRIEF.md
# Variable Block Size SAD Tree

This processing element scores one candidate block of a 16x16 macroblock match. Each cycle it may take a 4x4 tile of current pixels and the matching 4x4 tile of reference pixels, 8 bits per pixel, together with the position of that tile in the macroblock. Sixteen absolute differences are formed in parallel, summed into one 4x4 sum of absolute differences, and written into the base register picked by the position. Nothing is held before that write, so a base value shows on the outputs in the cycle after its tile is presented.

From the sixteen stored base sums, an adder network builds every partition shape of the macroblock: 4x4, 8 wide by 4 tall, 4 wide by 8 tall, 8x8, 8 wide by 16 tall, 16 wide by 8 tall and 16x16. That makes 41 values. Each larger value is the sum of smaller stored sums. No pixel is read twice. A shape's output is correct once all of its base tiles have been written. The done flag pulses once when the last missing tile of a macroblock arrives. A search controller then samples all 41 values and moves to the next candidate.

Top module: `sad_tree_vbs`

## Requirements
- R1: While reset is asserted, and after it until the first write, every SAD output and the done flag read zero.
- R2: When valid_i is high at a clock edge, the sum of the 16 absolute differences between cur_i and ref_i is stored as base SAD number blk_i and appears on sad4x4_o from the next cycle. Pixel k of a tile occupies bits [8k+7:8k]. Base k occupies sad4x4_o bits [12k+11:12k]. Blocks are numbered row by row, with b0..b3 in the top row.
- R3: The absolute difference is symmetric: exchanging the current and reference tiles gives the same base SAD.
- R4: A cycle with valid_i low changes no stored base SAD, whatever the tile and index inputs carry.
- R5: sad8x4_o entry j (13 bits) equals b(2j)+b(2j+1), the horizontal pair.
- R6: sad4x8_o entry j (13 bits) equals b(8r+c)+b(8r+c+4) with r=j/4 and c=j%4, the vertical pair.
- R7: sad8x8_o entry q (14 bits) is the quadrant whose top-left block is b(8*(q/2)+2*(q%2)), summing the 2x2 base blocks there.
- R8: sad8x16_o entry k (15 bits) covers block columns 2k and 2k+1 over all rows. sad16x8_o entry k covers block rows 2k and 2k+1 over all columns.
- R9: sad16_o (16 bits) is the sum of all 16 base values and reaches 65280 for an all-255 tile against an all-0 tile without wrapping.
- R10: done_o is high for exactly one cycle, in the cycle after the write that completes all 16 block indices of a macroblock. The next write after that starts a new macroblock with only its own index counted.
- R11: Writing an index again overwrites its base SAD. A repeated index does not count toward completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Tile pair present this cycle |
| blk_i | input | 4 | Base block position, 0..15, row by row |
| cur_i | input | 128 | Current 4x4 tile, 16 pixels |
| ref_i | input | 128 | Reference 4x4 tile, 16 pixels |
| sad4x4_o | output | 192 | 16 base SADs, 12 bits each |
| sad8x4_o | output | 104 | 8 horizontal pair SADs, 13 bits each |
| sad4x8_o | output | 104 | 8 vertical pair SADs, 13 bits each |
| sad8x8_o | output | 56 | 4 quadrant SADs, 14 bits each |
| sad8x16_o | output | 30 | 2 tall half SADs, 15 bits each |
| sad16x8_o | output | 30 | 2 wide half SADs, 15 bits each |
| sad16_o | output | 16 | Whole macroblock SAD |
| done_o | output | 1 | One-cycle pulse when all 16 blocks are present |

## Verification
The assertions check on every cycle that idle cycles leave the base sums untouched and that the whole-block total agrees whether it is reached through the tall halves or the wide halves. They also check that a horizontal pair equals its two bases, that no total exceeds the 8-bit worst case, and that done never lasts two cycles and only follows a write. Only the bench scenarios can show that each base value is the correct pixel SAD at the addressed position. The same holds for the row-major mapping behind every pair, quadrant and half, for the exact cycle in which done fires, for symmetry of the difference, and for the rule that overwrites and repeats do not complete a macroblock.

// File: rtl/sad_tree_pkg.sv
package sad_tree_pkg;
  localparam int PIX_W_DEF = 8;
  localparam int GRID      = 4;
  localparam int BLK_N     = GRID * GRID;
  localparam int LANES     = 16;
  localparam int IDX_W     = $clog2(BLK_N);
endpackage

// File: rtl/sad_absdiff_lane.sv
module sad_absdiff_lane #(
  parameter int PIX_W = 8
) (
  input  logic [PIX_W-1:0] a_i,
  input  logic [PIX_W-1:0] b_i,
  output logic [PIX_W-1:0] d_o
);
  logic [PIX_W:0] a_minus_b;
  logic [PIX_W:0] b_minus_a;

  always_comb begin
    a_minus_b = {1'b0, a_i} - {1'b0, b_i};
    b_minus_a = {1'b0, b_i} - {1'b0, a_i};
    // borrow out of a-b selects the other subtraction
    d_o = a_minus_b[PIX_W] ? b_minus_a[PIX_W-1:0] : a_minus_b[PIX_W-1:0];
  end
endmodule

// File: rtl/sad_tile_sum.sv
module sad_tile_sum
  import sad_tree_pkg::*;
#(
  parameter int PIX_W = 8,
  localparam int SUM_W = PIX_W + $clog2(LANES)
) (
  input  logic [LANES*PIX_W-1:0] cur_i,
  input  logic [LANES*PIX_W-1:0] ref_i,
  output logic [SUM_W-1:0]       sad_o
);
  logic [LANES*PIX_W-1:0] diffs;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    sad_absdiff_lane #(.PIX_W(PIX_W)) i_lane (
      .a_i(cur_i[k*PIX_W +: PIX_W]),
      .b_i(ref_i[k*PIX_W +: PIX_W]),
      .d_o(diffs[k*PIX_W +: PIX_W])
    );
  end

  function automatic logic [SUM_W-1:0] sum_lanes(input logic [LANES*PIX_W-1:0] v);
    logic [SUM_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < LANES; k++) acc = acc + SUM_W'(v[k*PIX_W +: PIX_W]);
    return acc;
  endfunction

  assign sad_o = sum_lanes(diffs);
endmodule

// File: rtl/sad_base_bank.sv
module sad_base_bank
  import sad_tree_pkg::*;
#(
  parameter int SAD_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en_i,
  input  logic [IDX_W-1:0]       wr_idx_i,
  input  logic [SAD_W-1:0]       wr_sad_i,
  output logic [BLK_N*SAD_W-1:0] base_o,
  output logic                   mb_start_o,
  output logic                   done_o
);
  logic [SAD_W-1:0] base_q [BLK_N];
  logic [BLK_N-1:0] seen_q;
  logic [BLK_N-1:0] seen_nx;
  logic [BLK_N-1:0] wr_sel;

  always_comb begin
    wr_sel     = BLK_N'(1) << wr_idx_i;
    mb_start_o = wr_en_i && (&seen_q);
    seen_nx    = ((&seen_q) ? '0 : seen_q) | wr_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BLK_N; i++) base_q[i] <= '0;
      seen_q <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (wr_en_i) begin
        for (int i = 0; i < BLK_N; i++)
          if (wr_sel[i]) base_q[i] <= wr_sad_i;
        seen_q <= seen_nx;
        done_o <= &seen_nx;
      end
    end
  end

  for (genvar i = 0; i < BLK_N; i++) begin : g_out
    assign base_o[i*SAD_W +: SAD_W] = base_q[i];
  end
endmodule

// File: rtl/sad_partition_tree.sv
module sad_partition_tree
  import sad_tree_pkg::*;
#(
  parameter int S4_W = 12,
  localparam int S2_W = S4_W + 1,
  localparam int S8_W = S4_W + 2,
  localparam int SH_W = S4_W + 3,
  localparam int SF_W = S4_W + 4
) (
  input  logic [BLK_N*S4_W-1:0] base_i,
  output logic [8*S2_W-1:0]     hpair_o,
  output logic [8*S2_W-1:0]     vpair_o,
  output logic [4*S8_W-1:0]     quad_o,
  output logic [2*SH_W-1:0]     tall_o,
  output logic [2*SH_W-1:0]     wide_o,
  output logic [SF_W-1:0]       full_o
);
  function automatic logic [S2_W-1:0] add_s4(input logic [S4_W-1:0] a, input logic [S4_W-1:0] b);
    return S2_W'(a) + S2_W'(b);
  endfunction
  function automatic logic [S8_W-1:0] add_s2(input logic [S2_W-1:0] a, input logic [S2_W-1:0] b);
    return S8_W'(a) + S8_W'(b);
  endfunction
  function automatic logic [SH_W-1:0] add_s8(input logic [S8_W-1:0] a, input logic [S8_W-1:0] b);
    return SH_W'(a) + SH_W'(b);
  endfunction
  function automatic logic [SF_W-1:0] add_sh(input logic [SH_W-1:0] a, input logic [SH_W-1:0] b);
    return SF_W'(a) + SF_W'(b);
  endfunction

  logic [S4_W-1:0] b [BLK_N];
  logic [S2_W-1:0] hp [8];
  logic [S8_W-1:0] qd [4];
  logic [SH_W-1:0] wd [2];

  for (genvar i = 0; i < BLK_N; i++) begin : g_unpack
    assign b[i] = base_i[i*S4_W +: S4_W];
  end

  for (genvar j = 0; j < 8; j++) begin : g_pairs
    localparam int R = j / GRID;
    localparam int C = j % GRID;
    localparam int TOP = 2 * GRID * R + C;
    assign hp[j] = add_s4(b[2*j], b[2*j+1]);
    assign hpair_o[j*S2_W +: S2_W] = hp[j];
    assign vpair_o[j*S2_W +: S2_W] = add_s4(b[TOP], b[TOP+GRID]);
  end

  // a quadrant is two stacked horizontal pairs
  for (genvar q = 0; q < 4; q++) begin : g_quad
    localparam int HJ = 4 * (q / 2) + (q % 2);
    assign qd[q] = add_s2(hp[HJ], hp[HJ+2]);
    assign quad_o[q*S8_W +: S8_W] = qd[q];
  end

  for (genvar k = 0; k < 2; k++) begin : g_half
    assign tall_o[k*SH_W +: SH_W] = add_s8(qd[k], qd[k+2]);
    assign wd[k] = add_s8(qd[2*k], qd[2*k+1]);
    assign wide_o[k*SH_W +: SH_W] = wd[k];
  end

  assign full_o = add_sh(wd[0], wd[1]);
endmodule

// File: rtl/sad_tree_vbs.sv
module sad_tree_vbs
  import sad_tree_pkg::*;
#(
  parameter int PIX_W = PIX_W_DEF,
  localparam int S4_W = PIX_W + $clog2(LANES),
  localparam int S2_W = S4_W + 1,
  localparam int S8_W = S4_W + 2,
  localparam int SH_W = S4_W + 3,
  localparam int SF_W = S4_W + 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   valid_i,
  input  logic [IDX_W-1:0]       blk_i,
  input  logic [LANES*PIX_W-1:0] cur_i,
  input  logic [LANES*PIX_W-1:0] ref_i,
  output logic [BLK_N*S4_W-1:0]  sad4x4_o,
  output logic [8*S2_W-1:0]      sad8x4_o,
  output logic [8*S2_W-1:0]      sad4x8_o,
  output logic [4*S8_W-1:0]      sad8x8_o,
  output logic [2*SH_W-1:0]      sad8x16_o,
  output logic [2*SH_W-1:0]      sad16x8_o,
  output logic [SF_W-1:0]        sad16_o,
  output logic                   done_o
);
  logic [S4_W-1:0] tile_sad;
  logic            mb_start;

  sad_tile_sum #(.PIX_W(PIX_W)) i_sum (
    .cur_i(cur_i),
    .ref_i(ref_i),
    .sad_o(tile_sad)
  );

  sad_base_bank #(.SAD_W(S4_W)) i_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (valid_i),
    .wr_idx_i  (blk_i),
    .wr_sad_i  (tile_sad),
    .base_o    (sad4x4_o),
    .mb_start_o(mb_start),
    .done_o    (done_o)
  );

  sad_partition_tree #(.S4_W(S4_W)) i_tree (
    .base_i (sad4x4_o),
    .hpair_o(sad8x4_o),
    .vpair_o(sad4x8_o),
    .quad_o (sad8x8_o),
    .tall_o (sad8x16_o),
    .wide_o (sad16x8_o),
    .full_o (sad16_o)
  );
endmodule

// File: rtl/sad_tree_vbs_chk.sv
module sad_tree_vbs_chk #(
  parameter int PIX_W = 8,
  localparam int S4_W = PIX_W + 4,
  localparam int S2_W = S4_W + 1,
  localparam int SH_W = S4_W + 3,
  localparam int SF_W = S4_W + 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 valid_i,
  input logic [16*S4_W-1:0]   sad4x4_o,
  input logic [8*S2_W-1:0]    sad8x4_o,
  input logic [2*SH_W-1:0]    sad8x16_o,
  input logic [SF_W-1:0]      sad16_o,
  input logic                 done_o
);
  localparam int MAX_FULL = ((1 << PIX_W) - 1) * 256;

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(sad4x4_o));

  p_hpair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sad8x4_o[S2_W-1:0] == S2_W'(sad4x4_o[S4_W-1:0]) + S2_W'(sad4x4_o[S4_W +: S4_W]));

  p_halves_agree_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sad16_o == SF_W'(sad8x16_o[SH_W-1:0]) + SF_W'(sad8x16_o[SH_W +: SH_W]));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sad16_o) <= MAX_FULL);

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(valid_i));
endmodule

bind sad_tree_vbs sad_tree_vbs_chk #(.PIX_W(PIX_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .valid_i  (valid_i),
  .sad4x4_o (sad4x4_o),
  .sad8x4_o (sad8x4_o),
  .sad8x16_o(sad8x16_o),
  .sad16_o  (sad16_o),
  .done_o   (done_o)
);

// File: tb/test_sad_tree_vbs.sv
module test_sad_tree_vbs;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0;
  logic [3:0]   blk_i = '0;
  logic [127:0] cur_i = '0;
  logic [127:0] ref_i = '0;
  logic [191:0] sad4x4_o;
  logic [103:0] sad8x4_o;
  logic [103:0] sad4x8_o;
  logic [55:0]  sad8x8_o;
  logic [29:0]  sad8x16_o;
  logic [29:0]  sad16x8_o;
  logic [15:0]  sad16_o;
  logic         done_o;

  int n_vec = 0;
  int n_bad = 0;
  int model_base [16];
  logic [15:0] model_seen = '0;

  always #2.5 clk = ~clk;

  sad_tree_vbs i_sad_tree_vbs (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .blk_i(blk_i),
    .cur_i(cur_i), .ref_i(ref_i), .sad4x4_o(sad4x4_o), .sad8x4_o(sad8x4_o),
    .sad4x8_o(sad4x8_o), .sad8x8_o(sad8x8_o), .sad8x16_o(sad8x16_o),
    .sad16x8_o(sad16x8_o), .sad16_o(sad16_o), .done_o(done_o)
  );

  task automatic check(input string req, input int actual, input int expected);
    n_vec++;
    if (actual != expected) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  function automatic int rect(input int bx, input int by, input int w, input int h);
    int s = 0;
    for (int y = 0; y < h; y++)
      for (int x = 0; x < w; x++) s += model_base[(by + y) * 4 + bx + x];
    return s;
  endfunction

  task automatic check_all(input string tag);
    for (int i = 0; i < 16; i++) check({"R2 base ", tag}, int'(sad4x4_o[i*12 +: 12]), model_base[i]);
    for (int j = 0; j < 8; j++) begin
      check({"R5 hpair ", tag}, int'(sad8x4_o[j*13 +: 13]), rect((2*j) % 4, (2*j) / 4, 2, 1));
      check({"R6 vpair ", tag}, int'(sad4x8_o[j*13 +: 13]), rect(j % 4, 2 * (j / 4), 1, 2));
    end
    for (int q = 0; q < 4; q++) check({"R7 quad ", tag}, int'(sad8x8_o[q*14 +: 14]), rect(2 * (q % 2), 2 * (q / 2), 2, 2));
    for (int k = 0; k < 2; k++) begin
      check({"R8 tall ", tag}, int'(sad8x16_o[k*15 +: 15]), rect(2 * k, 0, 2, 4));
      check({"R8 wide ", tag}, int'(sad16x8_o[k*15 +: 15]), rect(0, 2 * k, 4, 2));
    end
    check({"R9 full ", tag}, int'(sad16_o), rect(0, 0, 4, 4));
  endtask

  function automatic logic [7:0] pix(input int seed, input int k);
    return 8'((seed * 37 + k * 91 + seed * k * 13 + 5) & 255);
  endfunction

  // drive one tile pair; returns after the capturing edge
  task automatic put(input int idx, input logic [127:0] c, input logic [127:0] r, input bit exp_done);
    int s = 0;
    @(negedge clk);
    valid_i = 1'b1; blk_i = 4'(idx); cur_i = c; ref_i = r;
    @(negedge clk);
    valid_i = 1'b0;
    for (int k = 0; k < 16; k++) begin
      int a = int'(c[k*8 +: 8]);
      int b = int'(r[k*8 +: 8]);
      s += (a > b) ? a - b : b - a;
    end
    model_base[idx] = s;
    if (&model_seen) model_seen = '0;
    model_seen[idx] = 1'b1;
    check("R10 done flag", int'(done_o), int'(exp_done));
  endtask

  function automatic logic [127:0] tile(input int seed);
    logic [127:0] t;
    for (int k = 0; k < 16; k++) t[k*8 +: 8] = pix(seed, k);
    return t;
  endfunction

  task automatic t_reset;
    check("R1 done", int'(done_o), 0);
    check("R1 full", int'(sad16_o), 0);
    check_all("after reset R1");
  endtask

  task automatic t_zorder_mb;
    int order [16] = '{0,1,4,5,2,3,6,7,8,9,12,13,10,11,14,15};
    for (int n = 0; n < 16; n++) begin
      put(order[n], tile(n + 3), tile(n + 40), n == 15);
      if (n == 1) check("R5 first pair ready", int'(sad8x4_o[12:0]), model_base[0] + model_base[1]);
      if (n == 3) check("R7 first quad ready", int'(sad8x8_o[13:0]), rect(0, 0, 2, 2));
    end
    @(negedge clk);
    check("R10 done one cycle", int'(done_o), 0);
    check_all("zorder");
  endtask

  task automatic t_raster_mb;
    for (int n = 0; n < 16; n++) put(15 - n, tile(n * 7 + 1), tile(n * 3 + 90), n == 15);
    check_all("reverse order");
  endtask

  task automatic t_extremes;
    for (int n = 0; n < 16; n++) put(n, {128{1'b1}}, '0, n == 15);
    check("R9 max full", int'(sad16_o), 65280);
    check_all("extremes");
  endtask

  task automatic t_symmetric;
    int first;
    put(5, tile(11), tile(77), 1'b0);
    first = int'(sad4x4_o[5*12 +: 12]);
    put(5, tile(77), tile(11), 1'b0);
    check("R3 swap", int'(sad4x4_o[5*12 +: 12]), first);
  endtask

  task automatic t_hold;
    @(negedge clk);
    valid_i = 1'b0; blk_i = 4'd9; cur_i = tile(200); ref_i = tile(1);
    repeat (3) @(negedge clk);
    check_all("idle R4");
  endtask

  task automatic t_overwrite;
    // new macroblock already started by t_symmetric (index 5); repeat 3 twice
    put(3, tile(20), tile(21), 1'b0);
    put(3, tile(22), tile(60), 1'b0);
    check("R11 overwrite", int'(sad4x4_o[3*12 +: 12]), model_base[3]);
    for (int i = 0; i < 16; i++)
      if (i != 3 && i != 5) put(i, tile(i + 100), tile(i + 130), i == 15);
    check_all("overwrite R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zorder_mb();
    t_raster_mb();
    t_extremes();
    t_symmetric();
    t_hold();
    t_overwrite();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule